// File: doc/BRIEF.md
# Shared-RAM Mailbox Engine

This block is the host-side end of a mailbox that carries fixed 32-byte messages between the host and a coprocessor through a byte-wide shared RAM. The RAM holds two mirrored areas, one for sending and one for receiving. Each area has a channel-limit byte, one state byte per channel and one 32-byte slot per channel. Each channel steps through four handshake codes, and both sides update them: 0 free, 1 posted, 2 taken, 3 finished.

For a send, the host hands over a channel number and a full message on a valid/ready stream. The engine checks the channel against the channel-limit byte. If the channel state is not free it waits. It then fills the slot, marks the channel posted and pulses a doorbell. Next it polls until the coprocessor marks the channel finished, reads the reply out of the slot and frees the channel. Finally it offers the reply on an output stream. When no send is pending, the engine scans the receive channels in turn. A channel marked posted is claimed, and its message goes out on a stream. The engine then takes the host's reply from a second input stream, writes it into the slot and marks the channel finished.

Each stream follows the usual rules. A transfer happens on a rising edge with valid and ready both high. The engine holds its output valid and data steady until ready is seen, and it expects the same from the host. Back-pressure on an output stream stalls the engine, so it does no other RAM work until that beat is taken.

Top module: `mbx_engine`

## Requirements
- R1: During and straight after reset, snd_err, rep_valid, rx_valid and doorbell are low, and req_status reads 0 (nothing in progress).
- R2: The shared RAM uses these addresses. Send channel limit at 0x200, send state of channel c at 0x201+c, send slot byte i of channel c at 0x220+32c+i. Receive channel limit at 0x300, receive state at 0x301+c, receive slot at 0x320+32c+i. Slot byte i carries message bits [8i+7:8i]. Read data comes back on mem_rdata one cycle after a read is issued.
- R3: A send whose channel is at or above the send channel-limit byte, or at or above 7, is accepted with snd_err high for that one cycle. It writes nothing to RAM, rings no doorbell and produces no reply.
- R4: If the channel's send state is not 0, the request waits. req_status reads 1 and the slot is untouched until the state reads 0.
- R5: For an accepted send, all 32 slot bytes are written before the state byte is set to 1. The doorbell is high for exactly the one cycle in which that state write happens. req_status reads 2 from then until the reply is offered.
- R6: The engine polls the send state until it reads 3, copies the 32-byte reply, writes 0 to the state and then offers rep_chan/rep_data with req_status 3. These are held steady until rep_ready.
- R7: A receive state of 1 is changed to 2 before the message is offered on rx_valid/rx_chan/rx_data with req_status 6. The offer is held steady until rx_ready.
- R8: After delivery, the engine raises rxr_ready, takes rxr_data, writes it into the same slot and then sets the receive state to 3.
- R9: A pending send wins over the receive scan. The scan visits receive channels 0 to 6 in rotation and writes no state byte whose value is not 1.
- R10: The engine writes only codes 0 to 3 into state bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| snd_valid | input | 1 | Send request valid |
| snd_ready | output | 1 | Send request accepted |
| snd_chan | input | 3 | Send channel number |
| snd_data | input | 256 | Send message, byte i in bits [8i+7:8i] |
| snd_err | output | 1 | Channel rejected, one-cycle pulse |
| rep_valid | output | 1 | Reply valid |
| rep_ready | input | 1 | Reply taken |
| rep_chan | output | 3 | Channel of reply |
| rep_data | output | 256 | Reply bytes |
| rx_valid | output | 1 | Incoming message valid |
| rx_ready | input | 1 | Incoming message taken |
| rx_chan | output | 3 | Channel of incoming message |
| rx_data | output | 256 | Incoming message bytes |
| rxr_valid | input | 1 | Host reply valid |
| rxr_ready | output | 1 | Host reply accepted |
| rxr_data | input | 256 | Host reply bytes |
| doorbell | output | 1 | Coprocessor interrupt pulse |
| req_status | output | 3 | 0 none, 1 waiting, 2 sent, 3 complete, 6 unsolicited |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one cycle after the read |

## Verification
The hold checks on the reply and message streams, and the single-cycle doorbell check, only guard the engine's own outputs. They assume the RAM answers every read exactly one cycle later and that the host never changes rep_ready or rx_ready in a way that drops a beat it has not taken. The bench's RAM model follows that latency. The bench changes the coprocessor's side of the RAM only between clock edges, and only to codes the handshake allows: reply then 3 on send channels, message then 1 on receive channels. It holds every input stream until ready is seen.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    RG_SMAX, RG_SST, RG_SSLOT, RG_RST, RG_RSLOT
  } rgn_t;

  typedef enum logic [2:0] {
    RS_UNUSED = 3'd0, RS_WAIT = 3'd1, RS_SENT = 3'd2,
    RS_DONE = 3'd3, RS_UNSOL = 3'd6
  } req_st_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RMAX, ST_SCHK, ST_SWR, ST_POST, ST_SPOLL, ST_SRD,
    ST_SCLR, ST_SREP, ST_RCHK, ST_RRD, ST_ROUT, ST_RREP, ST_RWR, ST_RACK
  } fsm_t;

  localparam logic [7:0] CS_FREE = 8'd0;
  localparam logic [7:0] CS_POSTED = 8'd1;
  localparam logic [7:0] CS_TAKEN = 8'd2;
  localparam logic [7:0] CS_FINISHED = 8'd3;
endpackage

// File: rtl/mbx_addr.sv
module mbx_addr
  import mbx_pkg::*;
#(
  parameter int NCH = 7,
  parameter int BYTES = 32,
  parameter int ADDR_W = 16,
  parameter int SEND_BASE = 'h200,
  parameter int RECV_BASE = 'h300,
  parameter int SLOT_OFS = 32,
  parameter int CH_W = $clog2(NCH),
  parameter int IW = $clog2(BYTES) + 1
) (
  input  rgn_t              region,
  input  logic [CH_W-1:0]   chan,
  input  logic [IW-1:0]     idx,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] SB = ADDR_W'(SEND_BASE);
  localparam logic [ADDR_W-1:0] RB = ADDR_W'(RECV_BASE);

  logic [ADDR_W-1:0] base, slot;

  always_comb begin
    base = (region == RG_RST || region == RG_RSLOT) ? RB : SB;
    slot = base + ADDR_W'(SLOT_OFS) + ADDR_W'(chan) * ADDR_W'(BYTES) + ADDR_W'(idx);
    case (region)
      RG_SST, RG_RST:     addr = base + ADDR_W'(1) + ADDR_W'(chan);
      RG_SSLOT, RG_RSLOT: addr = slot;
      default:            addr = base;
    endcase
  end
endmodule

// File: rtl/mbx_buf.sv
module mbx_buf #(
  parameter int BYTES = 32,
  parameter int BW = $clog2(BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BYTES*8-1:0] load_data,
  input  logic               wr_en,
  input  logic [BW-1:0]      wr_idx,
  input  logic [7:0]         wr_byte,
  input  logic [BW-1:0]      rd_idx,
  output logic [7:0]         rd_byte,
  output logic [BYTES*8-1:0] data
);
  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             b_q <= '0;
      else if (load)                          b_q <= load_data[8*g +: 8];
      else if (wr_en && wr_idx == BW'(g))     b_q <= wr_byte;
    end
    assign data[8*g +: 8] = b_q;
  end

  assign rd_byte = data[8*rd_idx +: 8];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int NCH = 7,
  parameter int BYTES = 32,
  parameter int CH_W = $clog2(NCH),
  parameter int IW = $clog2(BYTES) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snd_valid,
  input  logic [CH_W-1:0] snd_chan,
  output logic            snd_ready,
  output logic            snd_err,
  output logic            rep_valid,
  input  logic            rep_ready,
  output logic            rx_valid,
  input  logic            rx_ready,
  input  logic            rxr_valid,
  output logic            rxr_ready,
  output logic            doorbell,
  output logic [2:0]      status,
  output logic [CH_W-1:0] cur_ch,
  output rgn_t            region,
  output logic [CH_W-1:0] ach,
  output logic [IW-1:0]   idx,
  output logic            mem_en,
  output logic            mem_we,
  output logic            use_buf,
  output logic [7:0]      code,
  input  logic [7:0]      mem_rdata,
  output logic            buf_load,
  output logic            load_sel,
  output logic            cap_en,
  output logic [IW-2:0]   cap_idx
);
  localparam logic [IW-1:0] LAST = IW'(BYTES - 1);
  localparam logic [IW-1:0] ENDI = IW'(BYTES);

  fsm_t st, nxt;
  logic [IW-1:0] idx_n;
  logic [CH_W-1:0] cur_n, scan_ch, scan_n;
  logic rvalid;
  req_st_t rs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; idx <= '0; cur_ch <= '0; scan_ch <= '0; rvalid <= 1'b0;
    end else begin
      st <= nxt; idx <= idx_n; cur_ch <= cur_n; scan_ch <= scan_n;
      rvalid <= mem_en & ~mem_we;
    end
  end

  function automatic logic [CH_W-1:0] nxt_ch(input logic [CH_W-1:0] c);
    return (c == CH_W'(NCH - 1)) ? '0 : c + CH_W'(1);
  endfunction

  always_comb begin
    nxt = st; idx_n = idx; cur_n = cur_ch; scan_n = scan_ch;
    region = RG_SMAX; ach = cur_ch; mem_en = 1'b0; mem_we = 1'b0;
    use_buf = 1'b0; code = CS_FREE; buf_load = 1'b0; load_sel = 1'b0;
    cap_en = 1'b0; cap_idx = '0; snd_ready = 1'b0; snd_err = 1'b0;
    rep_valid = 1'b0; rx_valid = 1'b0; rxr_ready = 1'b0; doorbell = 1'b0;
    rs = RS_UNUSED;
    case (st)
      ST_IDLE: begin
        mem_en = 1'b1;
        if (snd_valid) begin
          region = RG_SMAX; nxt = ST_RMAX;
        end else begin
          region = RG_RST; ach = scan_ch; nxt = ST_RCHK;
        end
      end
      ST_RMAX: begin
        snd_ready = 1'b1;
        if ({{(8-CH_W){1'b0}}, snd_chan} >= mem_rdata || snd_chan >= CH_W'(NCH)) begin
          snd_err = 1'b1; nxt = ST_IDLE;
        end else begin
          buf_load = 1'b1; cur_n = snd_chan;
          mem_en = 1'b1; region = RG_SST; ach = snd_chan; nxt = ST_SCHK;
        end
      end
      ST_SCHK: begin
        rs = RS_WAIT; region = RG_SST;
        if (rvalid && mem_rdata == CS_FREE) begin
          nxt = ST_SWR; idx_n = '0;
        end else mem_en = 1'b1;
      end
      ST_SWR, ST_RWR: begin
        rs = (st == ST_SWR) ? RS_SENT : RS_UNSOL;
        region = (st == ST_SWR) ? RG_SSLOT : RG_RSLOT;
        mem_en = 1'b1; mem_we = 1'b1; use_buf = 1'b1;
        if (idx == LAST) begin
          idx_n = '0; nxt = (st == ST_SWR) ? ST_POST : ST_RACK;
        end else idx_n = idx + IW'(1);
      end
      ST_POST: begin
        rs = RS_SENT; region = RG_SST; mem_en = 1'b1; mem_we = 1'b1;
        code = CS_POSTED; doorbell = 1'b1; nxt = ST_SPOLL;
      end
      ST_SPOLL: begin
        rs = RS_SENT; region = RG_SST; mem_en = 1'b1;
        if (rvalid && mem_rdata == CS_FINISHED) begin
          nxt = ST_SRD; idx_n = '0;
        end
      end
      ST_SRD, ST_RRD: begin
        rs = (st == ST_SRD) ? RS_SENT : RS_UNSOL;
        region = (st == ST_SRD) ? RG_SSLOT : RG_RSLOT;
        mem_en = (idx != ENDI);
        if (idx != '0) begin
          cap_en = 1'b1; cap_idx = (IW-1)'(idx - IW'(1));
        end
        if (idx == ENDI) begin
          idx_n = '0; nxt = (st == ST_SRD) ? ST_SCLR : ST_ROUT;
        end else idx_n = idx + IW'(1);
      end
      ST_SCLR: begin
        rs = RS_SENT; region = RG_SST; mem_en = 1'b1; mem_we = 1'b1;
        code = CS_FREE; nxt = ST_SREP;
      end
      ST_SREP: begin
        rs = RS_DONE; rep_valid = 1'b1;
        if (rep_ready) nxt = ST_IDLE;
      end
      ST_RCHK: begin
        if (rvalid && mem_rdata == CS_POSTED) begin
          rs = RS_UNSOL; region = RG_RST; ach = scan_ch; mem_en = 1'b1;
          mem_we = 1'b1; code = CS_TAKEN; cur_n = scan_ch;
          idx_n = '0; nxt = ST_RRD;
        end else begin
          scan_n = nxt_ch(scan_ch); nxt = ST_IDLE;
        end
      end
      ST_ROUT: begin
        rs = RS_UNSOL; rx_valid = 1'b1;
        if (rx_ready) nxt = ST_RREP;
      end
      ST_RREP: begin
        rs = RS_UNSOL; rxr_ready = 1'b1;
        if (rxr_valid) begin
          buf_load = 1'b1; load_sel = 1'b1; idx_n = '0; nxt = ST_RWR;
        end
      end
      ST_RACK: begin
        rs = RS_UNSOL; region = RG_RST; mem_en = 1'b1; mem_we = 1'b1;
        code = CS_FINISHED; scan_n = nxt_ch(cur_ch); nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
    status = rs;
  end

  AST_BELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell); // R5
  AST_ERR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    snd_err |-> snd_ready && !rep_valid); // R3
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rep_valid, rx_valid, rxr_ready, snd_ready})); // R9
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int NCH = 7,
  parameter int BYTES = 32,
  parameter int ADDR_W = 16,
  parameter int SEND_BASE = 'h200,
  parameter int RECV_BASE = 'h300,
  parameter int SLOT_OFS = 32,
  localparam int CH_W = $clog2(NCH),
  localparam int DW = BYTES * 8,
  localparam int IW = $clog2(BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snd_valid,
  output logic              snd_ready,
  input  logic [CH_W-1:0]   snd_chan,
  input  logic [DW-1:0]     snd_data,
  output logic              snd_err,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic [CH_W-1:0]   rep_chan,
  output logic [DW-1:0]     rep_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [CH_W-1:0]   rx_chan,
  output logic [DW-1:0]     rx_data,
  input  logic              rxr_valid,
  output logic              rxr_ready,
  input  logic [DW-1:0]     rxr_data,
  output logic              doorbell,
  output logic [2:0]        req_status,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  rgn_t region;
  logic [CH_W-1:0] ach, cur_ch;
  logic [IW-1:0] idx;
  logic [IW-2:0] cap_idx;
  logic use_buf, buf_load, load_sel, cap_en;
  logic [7:0] code, buf_byte;
  logic [DW-1:0] buf_data;

  mbx_ctrl #(.NCH(NCH), .BYTES(BYTES)) ctrl_i (
    .clk, .rst_n, .snd_valid, .snd_chan, .snd_ready, .snd_err,
    .rep_valid, .rep_ready, .rx_valid, .rx_ready, .rxr_valid, .rxr_ready,
    .doorbell, .status(req_status), .cur_ch, .region, .ach, .idx,
    .mem_en, .mem_we, .use_buf, .code, .mem_rdata, .buf_load, .load_sel,
    .cap_en, .cap_idx
  );

  mbx_addr #(.NCH(NCH), .BYTES(BYTES), .ADDR_W(ADDR_W), .SEND_BASE(SEND_BASE),
             .RECV_BASE(RECV_BASE), .SLOT_OFS(SLOT_OFS)) addr_i (
    .region, .chan(ach), .idx, .addr(mem_addr)
  );

  mbx_buf #(.BYTES(BYTES)) buf_i (
    .clk, .rst_n, .load(buf_load), .load_data(load_sel ? rxr_data : snd_data),
    .wr_en(cap_en), .wr_idx(cap_idx), .wr_byte(mem_rdata),
    .rd_idx(idx[IW-2:0]), .rd_byte(buf_byte), .data(buf_data)
  );

  assign mem_wdata = use_buf ? buf_byte : code;
  assign rep_chan  = cur_ch;
  assign rx_chan   = cur_ch;
  assign rep_data  = buf_data;
  assign rx_data   = buf_data;

  AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep_data) && $stable(rep_chan)); // R6
  AST_RXMSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_chan)); // R7
  AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && (region == RG_SST || region == RG_RST) |-> mem_wdata <= 8'd3); // R10
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid || rx_valid |-> !mem_en); // R6
endmodule

// File: tb/mbx_engine_tb_top.sv
`timescale 1ns/1ps
module mbx_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic snd_valid = 0, snd_ready, snd_err, rep_valid, rep_ready = 0;
  logic [2:0] snd_chan = 0, rep_chan, rx_chan, req_status;
  logic [255:0] snd_data = '0, rep_data, rx_data, rxr_data = '0;
  logic rx_valid, rx_ready = 0, rxr_valid = 0, rxr_ready, doorbell;
  logic mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] ram [0:1023];

  int checks = 0, fails = 0, bells = 0;
  bit rx_seen = 0, finished = 0;

  mbx_engine dut_i (.*);

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
      else mem_rdata <= ram[mem_addr[9:0]];
    end
    if (doorbell) bells <= bells + 1;
    if (rx_valid) rx_seen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(int c, int i, int s);
    return 8'((c * 29 + i * 7 + s * 13 + 3) & 255);
  endfunction
  function automatic logic [7:0] rb(int c, int i, int s);
    return 8'(((c * 53 + i * 11 + s * 5) & 255) ^ 'h5A);
  endfunction

  function automatic int send_sum();
    int s = 0;
    for (int a = 'h201; a < 'h300; a++) s += int'(ram[a]) * (a - 'h1F0);
    return s;
  endfunction

  task automatic wait_neg(ref logic sig, input string req);
    int n = 0;
    while (!sig && n < 400) begin @(negedge clk); n++; end
    chk(n < 400, req, 0, 1);
  endtask

  task automatic send_msg(int c, bit blocked, int s, int rxc);
    logic [255:0] d, r, slot;
    int sum0, b0;
    bit rx_at_bell;
    for (int i = 0; i < 32; i++) begin
      d[8*i +: 8] = mb(c, i, s);
      r[8*i +: 8] = rb(c, i, s);
    end
    if (blocked) ram['h201 + c] = 8'd2;
    @(negedge clk);
    if (rxc >= 0) begin
      for (int i = 0; i < 32; i++) ram['h320 + 32*rxc + i] = mb(rxc, i, s + 1);
      ram['h301 + rxc] = 8'd1;
      rx_seen = 0;
    end
    snd_valid = 1; snd_chan = 3'(c); snd_data = d;
    wait_neg(snd_ready, "R3");
    chk(!snd_err, "R3", 256'(snd_err), 0);
    @(negedge clk); snd_valid = 0;
    if (blocked) begin
      sum0 = send_sum(); b0 = bells;
      repeat (20) @(negedge clk);
      chk(req_status == 3'd1, "R4", 256'(req_status), 1);
      chk(send_sum() == sum0 && bells == b0, "R4", 256'(bells), 256'(b0));
      ram['h201 + c] = 8'd0;
    end
    wait_neg(doorbell, "R5");
    rx_at_bell = rx_seen;
    chk(req_status == 3'd2, "R5", 256'(req_status), 2);
    @(negedge clk);
    chk(!doorbell, "R5", 256'(doorbell), 0);
    chk(ram['h201 + c] == 8'd1, "R5", 256'(ram['h201 + c]), 1);
    for (int i = 0; i < 32; i++) slot[8*i +: 8] = ram['h220 + 32*c + i];
    chk(slot == d, "R2", slot, d);
    if (rxc >= 0) chk(!rx_at_bell, "R9", 256'(rx_at_bell), 0);
    repeat (3 + c) @(negedge clk);
    chk(req_status == 3'd2 && !rep_valid, "R6", 256'(rep_valid), 0);
    for (int i = 0; i < 32; i++) ram['h220 + 32*c + i] = r[8*i +: 8];
    ram['h201 + c] = 8'd3;
    wait_neg(rep_valid, "R6");
    chk(rep_data == r && rep_chan == 3'(c), "R6", rep_data, r);
    chk(req_status == 3'd3, "R6", 256'(req_status), 3);
    chk(ram['h201 + c] == 8'd0, "R6", 256'(ram['h201 + c]), 0);
    repeat (2) @(negedge clk);
    chk(rep_valid && rep_data == r, "R6", rep_data, r);
    rep_ready = 1; @(negedge clk); rep_ready = 0;
    chk(!rep_valid && req_status == 3'd0, "R6", 256'(req_status), 0);
  endtask

  task automatic reject(int c);
    int sum0 = send_sum(), b0 = bells;
    bit got = 0;
    @(negedge clk); snd_valid = 1; snd_chan = 3'(c); snd_data = '1;
    wait_neg(snd_ready, "R3");
    chk(snd_err, "R3", 256'(snd_err), 1);
    @(negedge clk); snd_valid = 0;
    chk(!snd_err, "R3", 256'(snd_err), 0);
    repeat (20) begin @(negedge clk); got |= rep_valid; end
    chk(!got && bells == b0 && send_sum() == sum0, "R3", 256'(bells), 256'(b0));
  endtask

  task automatic rx_post(int c, int s);
    @(negedge clk);
    for (int i = 0; i < 32; i++) ram['h320 + 32*c + i] = mb(c, i, s);
    ram['h301 + c] = 8'd1;
  endtask

  task automatic rx_finish(int c, int s);
    logic [255:0] d, r, slot;
    int n = 0;
    for (int i = 0; i < 32; i++) begin
      d[8*i +: 8] = mb(c, i, s);
      r[8*i +: 8] = rb(c, i, s);
    end
    wait_neg(rx_valid, "R7");
    chk(rx_chan == 3'(c) && rx_data == d, "R7", rx_data, d);
    chk(ram['h301 + c] == 8'd2 && req_status == 3'd6, "R7", 256'(ram['h301 + c]), 2);
    repeat (3) @(negedge clk);
    chk(rx_valid && rx_data == d, "R7", rx_data, d);
    rx_ready = 1; @(negedge clk); rx_ready = 0;
    rxr_valid = 1; rxr_data = r;
    wait_neg(rxr_ready, "R8");
    @(negedge clk); rxr_valid = 0;
    while (ram['h301 + c] != 8'd3 && n < 200) begin @(negedge clk); n++; end
    chk(ram['h301 + c] == 8'd3, "R8", 256'(ram['h301 + c]), 3);
    for (int i = 0; i < 32; i++) slot[8*i +: 8] = ram['h320 + 32*c + i];
    chk(slot == r, "R8", slot, r);
    ram['h301 + c] = 8'd0;
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) ram[a] = 8'd0;
    ram['h200] = 8'd5; ram['h300] = 8'd7;
    repeat (4) @(negedge clk);
    chk(!rep_valid && !rx_valid && !doorbell && !snd_err && req_status == 0, "R1", 256'(req_status), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rep_valid && !rx_valid && !doorbell && req_status == 0, "R1", 256'(req_status), 0);
    for (int c = 0; c < 5; c++) send_msg(c, 0, 1, -1);
    send_msg(1, 1, 2, -1);
    reject(5); reject(6); reject(7);
    ram['h200] = 8'd7;
    send_msg(6, 0, 3, -1);
    reject(7);
    for (int c = 0; c < 7; c++) begin rx_post(c, 4); rx_finish(c, 4); end
    @(negedge clk); ram['h305] = 8'd2; ram['h303] = 8'd3;
    repeat (60) @(negedge clk);
    chk(ram['h305] == 8'd2 && ram['h303] == 8'd3 && !rx_valid, "R9", 256'(ram['h305]), 2);
    ram['h305] = 8'd0; ram['h303] = 8'd0;
    send_msg(0, 0, 5, 3);
    rx_finish(3, 6);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule